// File: doc/BRIEF.md
# Reloadable Countdown Timer with Interrupt

A single down-counting timer channel behind a plain 32-bit register port (address, write strobe, write data, read strobe, read data). Software programs an interval, optionally a first count, a clock source and a power-of-two prescale, then sets the run bit. Each prescaled tick lowers the count by one. When the count runs out, the channel raises a pending flag. It then either reloads the interval and keeps running, or stops.

The interrupt line is the pending flag gated by a one-bit enable. The flag is cleared by writing 1 to it. Writing the current-count register directly gives a first delay that can differ from the reload interval. After a one-shot expiry, one control write that sets both the reload bit and the run bit moves the channel into periodic operation.

Top module: `rld_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `irq` is low.
- R2: The register map is as follows. Byte address 0x00 holds the interrupt gate in bit 0. Address 0x04 holds the pending flag in bit 0. Address 0x10 is the control register: bit 0 run, bit 1 reload, bit 2 source select, bits [7:4] prescale code. Address 0x14 holds the interval and address 0x18 the current count, each CNT_W bits wide. Bit 3 of control, all other unused bits and all unmapped addresses read 0. Read data is registered and valid in the cycle after `bus_re`.
- R3: While run is set, the current count drops by one on each prescaled tick. While run is clear, the count holds.
- R4: With source select clear, every clock cycle is a base tick. With it set, only cycles with `osc_tick` high are base ticks.
- R5: Prescale code c divides the base ticks by 2^c, and the first prescaled tick comes 2^c base ticks after run is set. Codes above PRE_MAX (7) act as PRE_MAX.
- R6: A tick that meets a count of 1 or 0 is an expiry. It sets the pending flag on that same clock edge.
- R7: On expiry with reload set, the count reloads from the interval, so later expiries are exactly interval ticks apart.
- R8: On expiry with reload clear, the count goes to 0 and hardware clears the run bit. A later write of run and reload together restarts the channel, and its first tick is an expiry.
- R9: A write to the current count loads the counter directly and takes priority over a tick in the same cycle. This sets the delay to the next expiry independently of the interval.
- R10: Writing 1 to status bit 0 clears the pending flag, and writing 0 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R11: `irq` is registered and equals pending AND interrupt gate. It changes on the same edge as either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle strobe from the external oscillator, already synchronous to clk |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W at 16, ADDR_W at 8 and PRE_MAX at 7. The narrow count makes the zero-filled upper bits of the count registers visible on readback. The full prescale range lets a code of 9 be clamped to a 128-cycle period. Random trials use intervals of 4 to 15 with codes 0 to 3, so every expiry falls within a few hundred cycles. A clear write can therefore be placed on the exact edge of an expiry, and the period after the first one can be measured against interval times 2^code.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;
  localparam logic [7:0] OFS_GATE = 8'h00;
  localparam logic [7:0] OFS_PEND = 8'h04;
  localparam logic [7:0] OFS_CTL  = 8'h10;
  localparam logic [7:0] OFS_IVL  = 8'h14;
  localparam logic [7:0] OFS_CUR  = 8'h18;

  typedef struct packed {
    logic [3:0] pre;
    logic       src;
    logic       reload;
    logic       run;
  } ctl_t;
endpackage

// File: rtl/rld_timer_prescale.sv
module rld_timer_prescale #(
  parameter int PRE_MAX = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       src_osc,
  input  logic       osc_tick,
  input  logic [3:0] code,
  output logic       tick
);
  localparam int DIV_W = (PRE_MAX < 1) ? 1 : PRE_MAX;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [3:0]       eff;
  logic             base;

  assign base = src_osc ? osc_tick : 1'b1;
  assign eff  = (code > 4'(PRE_MAX)) ? 4'(PRE_MAX) : code;
  assign mask = ~({DIV_W{1'b1}} << eff);
  assign tick = run && base && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (base)   div_q <= div_q + 1'b1;
  end

  // with a divider above 1 and a steady code, ticks never fall on back-to-back cycles
  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && eff != 4'd0) ##1 $stable(eff) |-> !tick);
  assert_osc_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (src_osc && !osc_tick) |-> !tick);
endmodule

// File: rtl/rld_timer_core.sv
module rld_timer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] ivl,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  assign expire = tick && !load_we && (cur <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)          cur <= '0;
    else if (load_we) cur <= load_val;
    else if (expire)  cur <= reload ? ivl : '0;
    else if (tick)    cur <= cur - 1'b1;
  end

  assert_dec_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_we && cur > CNT_W'(1)) |=> cur == $past(cur) - 1'b1);
  assert_reload_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && reload) |=> cur == $past(ivl));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_we) |=> $stable(cur));
  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    load_we |=> cur == $past(load_val));
endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import rld_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int PRE_MAX = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  ctl_t             ctl_q;
  logic             gate_q, pend_q, irq_q;
  logic             gate_d, pend_d;
  logic [CNT_W-1:0] ivl_q, cur;
  logic [31:0]      rdata_q, rmux;
  logic             tick, expire;
  logic             we_gate, we_pend, we_ctl, we_ivl, we_cur, clr_pend;

  assign we_gate  = bus_we && bus_addr == ADDR_W'(OFS_GATE);
  assign we_pend  = bus_we && bus_addr == ADDR_W'(OFS_PEND);
  assign we_ctl   = bus_we && bus_addr == ADDR_W'(OFS_CTL);
  assign we_ivl   = bus_we && bus_addr == ADDR_W'(OFS_IVL);
  assign we_cur   = bus_we && bus_addr == ADDR_W'(OFS_CUR);
  assign clr_pend = we_pend && bus_wdata[0];

  rld_timer_prescale #(.PRE_MAX(PRE_MAX)) u_pre (
    .clk(clk), .rst(rst), .run(ctl_q.run), .src_osc(ctl_q.src),
    .osc_tick(osc_tick), .code(ctl_q.pre), .tick(tick)
  );

  rld_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .reload(ctl_q.reload), .ivl(ivl_q),
    .load_we(we_cur), .load_val(bus_wdata[CNT_W-1:0]), .cur(cur), .expire(expire)
  );

  // next-state of the flag and gate, shared by the registers and the irq flop
  always_comb begin
    pend_d = expire || (pend_q && !clr_pend);
    gate_d = we_gate ? bus_wdata[0] : gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      gate_q <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      ivl_q  <= '0;
    end else begin
      gate_q <= gate_d;
      pend_q <= pend_d;
      irq_q  <= pend_d && gate_d;
      if (we_ivl) ivl_q <= bus_wdata[CNT_W-1:0];
      if (we_ctl) begin
        ctl_q.pre    <= bus_wdata[7:4];
        ctl_q.src    <= bus_wdata[2];
        ctl_q.reload <= bus_wdata[1];
        ctl_q.run    <= bus_wdata[0];
      end else if (expire && !ctl_q.reload) begin
        ctl_q.run <= 1'b0;
      end
    end
  end

  always_comb begin
    rmux = '0;
    if (bus_addr == ADDR_W'(OFS_GATE))     rmux = {31'b0, gate_q};
    else if (bus_addr == ADDR_W'(OFS_PEND)) rmux = {31'b0, pend_q};
    else if (bus_addr == ADDR_W'(OFS_CTL))
      rmux = {24'b0, ctl_q.pre, 1'b0, ctl_q.src, ctl_q.reload, ctl_q.run};
    else if (bus_addr == ADDR_W'(OFS_IVL))  rmux = 32'(ivl_q);
    else if (bus_addr == ADDR_W'(OFS_CUR))  rmux = 32'(cur);
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_re) rdata_q <= rmux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    expire |=> pend_q);
  assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_pend && !expire) |=> !pend_q);
  assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctl_q.reload && !we_ctl) |=> !ctl_q.run);
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q == (pend_q && gate_q));
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !clr_pend) |=> pend_q);
endmodule

// File: tb/rld_timer_test.sv
module rld_timer_test;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_GATE = 8'h00, A_PEND = 8'h04, A_CTL = 8'h10,
                         A_IVL = 8'h14, A_CUR = 8'h18;

  logic clk = 1'b0, rst = 1'b1, osc_tick = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rld_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PRE_MAX(7)) uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int exp_period(int n, int code);
    int c = (code > 7) ? 7 : code;
    return ((n < 1) ? 1 : n) << c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!irq && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic quiesce();
    wr(A_CTL, 0);
    wr(A_PEND, 1);
  endtask

  // measures first delay, clears, then the following period
  task automatic periodic(string req, int first, int ivl, int code);
    int k, j;
    quiesce();
    wr(A_IVL, ivl);
    wr(A_CUR, first);
    wr(A_GATE, 1);
    wr(A_CTL, (code << 4) | 3);
    wait_irq(k);
    check({req, " first delay"}, k, exp_period(first, code));
    wr(A_PEND, 1);
    wait_irq(j);
    check({req, " period"}, j + 2, exp_period(ivl, code));
  endtask

  initial begin
    logic [31:0] d;
    int k;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", irq, 0);
    rd(A_CTL, d);  check("R1 ctl", d, 0);
    rd(A_CUR, d);  check("R1 cur", d, 0);
    rd(A_PEND, d); check("R1 pend", d, 0);
    rd(A_GATE, d); check("R1 gate", d, 0);

    // R2 field layout and zero bits
    wr(A_CTL, 32'hFFFF_FFF6);
    rd(A_CTL, d);  check("R2 ctl readback", d, 32'hF6);
    wr(A_GATE, 32'hFFFF_FFFF);
    rd(A_GATE, d); check("R2 gate readback", d, 1);
    wr(A_IVL, 32'h1234_ABCD);
    rd(A_IVL, d);  check("R2 ivl width", d, 32'h0000_ABCD);
    rd(8'h08, d);  check("R2 unmapped", d, 0);
    wr(A_GATE, 0);

    // R3 hold while stopped
    quiesce();
    wr(A_CUR, 20);
    repeat (10) @(negedge clk);
    rd(A_CUR, d);  check("R3 hold when stopped", d, 20);

    // R4 oscillator source: no strobes, no counting; 10 strobes, 10 ticks
    wr(A_CUR, 50);
    wr(A_CTL, 32'h5);
    repeat (10) @(negedge clk);
    rd(A_CUR, d);  check("R4 no strobe", d, 50);
    @(negedge clk); osc_tick = 1'b1;
    repeat (10) @(negedge clk);
    osc_tick = 1'b0;
    rd(A_CUR, d);  check("R4 strobe count", d, 40);

    // R6 R8 one-shot with a first count unlike the interval
    quiesce();
    wr(A_GATE, 1);
    wr(A_IVL, 9);
    wr(A_CUR, 5);
    wr(A_CTL, 1);
    wait_irq(k);   check("R6 one-shot delay", k, 5);
    rd(A_CTL, d);  check("R8 run cleared", d, 0);
    rd(A_CUR, d);  check("R8 count zero", d, 0);
    wr(A_PEND, 1);
    repeat (20) @(negedge clk);
    check("R8 stays stopped", irq, 0);
    wr(A_CTL, 3);
    wait_irq(k);   check("R8 restart expires on first tick", k, 1);
    wr(A_PEND, 1);
    wait_irq(k);   check("R8 R7 periodic after restart", k + 2, 9);

    // R9 R7 first delay differs from interval
    periodic("R9", 3, 7, 0);

    // R9 write while running
    quiesce();
    wr(A_IVL, 100);
    wr(A_CUR, 100);
    wr(A_CTL, 3);
    repeat (5) @(negedge clk);
    wr(A_CUR, 2);
    wait_irq(k);   check("R9 load while running", k, 2);

    // R5 clamped code
    quiesce();
    wr(A_IVL, 1);
    wr(A_CUR, 1);
    wr(A_CTL, 32'h93);
    wait_irq(k);   check("R5 code 9 clamps to 7", k, 128);

    // R10 set wins over clear on the expiry edge, write 0 ignored
    quiesce();
    wr(A_CUR, 6);
    wr(A_CTL, 1);
    repeat (4) @(negedge clk);
    wr(A_PEND, 1);
    check("R10 set wins irq", irq, 1);
    rd(A_PEND, d); check("R10 set wins flag", d, 1);
    wr(A_PEND, 0);
    rd(A_PEND, d); check("R10 write 0 ignored", d, 1);
    wr(A_PEND, 1);
    rd(A_PEND, d); check("R10 write 1 clears", d, 0);

    // R11 gating
    wr(A_CTL, 0);
    wr(A_GATE, 0);
    wr(A_CUR, 2);
    wr(A_CTL, 1);
    repeat (4) @(negedge clk);
    check("R11 gated off", irq, 0);
    rd(A_PEND, d); check("R11 flag set while gated", d, 1);
    wr(A_GATE, 1);
    check("R11 gate on", irq, 1);

    // R3 R5 R7 random periodic trials
    for (int t = 0; t < 12; t++) begin
      int n = 4 + int'($urandom_range(11));
      int c = int'($urandom_range(3));
      periodic("R7 R5 random", n, n, c);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule